// File: doc/BRIEF.md
# Serial Debug Command Engine

This block sits behind the byte receiver of a serial debug or programming link and interprets the incoming bytes as a compact instruction set. Each instruction is one opcode byte. Argument and data bytes may follow it. The instructions read or write a byte-wide internal bus. The address comes either directly from the byte stream or from an internal 32-bit pointer. Bytes that are read are handed to the link's transmitter through a valid/ready handshake.

Accesses span 1 to 4 bytes. The engine always performs them as a run of single-byte bus cycles, and each bus cycle waits for the bus ready input. The pointer can be used as is, advanced after each byte, or read and written itself. A reset-control register drives a device reset output, which is combined with an external reset request. Two consecutive BREAK indications from the receiver throw away a partly received instruction.

Controller states: IDLE (wait for an opcode), ADDR (collect address bytes), WDATA (wait for a write byte), BUSWR (bus write cycle), BUSRD (bus read cycle), TXBYTE (offer a byte to the transmitter), RSTDATA (wait for the reset-register byte). The transitions are:

- IDLE to ADDR on a direct opcode.
- IDLE to WDATA on an indirect store.
- IDLE to BUSRD on an indirect bus load.
- IDLE to TXBYTE on a pointer read.
- IDLE to RSTDATA on a reset-register write.
- ADDR to BUSRD (load) or to WDATA (store) after the last address byte.
- WDATA to BUSWR, or WDATA staying in WDATA for pointer writes. WDATA returns to IDLE after the last pointer byte.
- BUSWR to WDATA, or to IDLE after the last byte.
- BUSRD to TXBYTE.
- TXBYTE to BUSRD, or staying in TXBYTE for pointer reads. TXBYTE returns to IDLE after the last byte.
- RSTDATA to IDLE.
- Any state to IDLE on resynchronisation.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcode bits [7:5] select the instruction: 000 direct load, 010 direct store, 001 indirect load, 011 indirect store, 110 reset-register write. Bits [3:2] hold the address size minus one for direct instructions, or the pointer mode for indirect ones (00 bus, 01 bus with post-increment, 10 pointer itself). Bits [1:0] hold the data size minus one. Any opcode with bit 4 set, with bits [7:5] equal to 100, 101 or 111, or with indirect mode 11 is ignored: no bus cycle, no state change, and the next byte is taken as an opcode.
- R2: A direct store takes its address bytes (size = bits[3:2]+1), least significant first and zero-extended to 32 bits, then its data bytes. Data byte i is written by one bus write at address+i. No bus cycle starts before all address bytes have arrived.
- R3: A direct load takes its address bytes the same way, then performs data-size bus reads at address+i. Each byte read is offered on the transmit port before the next bus read.
- R4: A bus read or write strobe stays asserted, with address and write data stable, until bus_ready is high. Read and write strobes are never high together.
- R5: tx_valid stays high with tx_data stable until tx_ready is high.
- R6: Indirect mode 00 accesses every byte at the pointer address and leaves the pointer unchanged.
- R7: Indirect mode 01 increments the pointer after each byte access, wrapping modulo 2^32.
- R8: Indirect load in mode 10 returns pointer bytes least significant first, with no bus cycle.
- R9: Indirect store in mode 10 writes pointer byte i from data byte i. It leaves the other pointer bytes unchanged and starts no bus cycle.
- R10: The reset-register write (opcode 110, then one byte) drives dev_reset high for a nonzero byte. A zero byte releases it, unless ext_rst_req is high.
- R11: Two brk_pulse indications with no accepted byte between them abandon the current instruction and return to IDLE. A single BREAK changes nothing.
- R12: Synchronous active-high rst clears the pointer, the reset register and the controller state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Engine accepts a byte |
| brk_pulse | input | 1 | One-cycle BREAK indication |
| tx_data | output | 8 | Byte for the transmitter |
| tx_valid | output | 1 | tx_data present |
| tx_ready | input | 1 | Transmitter takes the byte |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_ready | input | 1 | Bus cycle completes |
| ext_rst_req | input | 1 | Other active reset request |
| dev_reset | output | 1 | Device reset output |

## Verification
The pointer and the reset register update on the edge that accepts the relevant byte, so dev_reset and later pointer reads reflect them one falling edge after the send completes. A bus strobe rises on the edge after the last address byte or the write byte is taken. A read byte appears on tx_data on the edge after bus_ready. The bench never samples at a fixed offset. It drives and samples on falling edges and follows the handshakes. It waits for rx_ready before each byte, waits for tx_valid before taking a byte, and waits for rx_ready to return before comparing results of a store.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam logic [2:0] OP_LD_DIR = 3'b000;
    localparam logic [2:0] OP_LD_IND = 3'b001;
    localparam logic [2:0] OP_ST_DIR = 3'b010;
    localparam logic [2:0] OP_ST_IND = 3'b011;
    localparam logic [2:0] OP_RST_WR = 3'b110;

    localparam logic [1:0] PM_BUS = 2'b00;
    localparam logic [1:0] PM_INC = 2'b01;
    localparam logic [1:0] PM_PTR = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_BUSWR,
        ST_BUSRD,
        ST_TXBYTE,
        ST_RSTDATA
    } eng_state_t;

    typedef struct packed {
        logic       valid;
        logic       is_load;
        logic       indirect;
        logic       rst_wr;
        logic [1:0] asz;
        logic [1:0] pmode;
        logic [1:0] dsz;
    } dec_t;

endpackage

// File: rtl/dbg_opcode_dec.sv
module dbg_opcode_dec
    import dbg_pkg::*;
(
    input  logic [7:0] op_i,
    output dec_t       dec_o
);
    logic [2:0] grp;

    always_comb begin
        grp            = op_i[7:5];
        dec_o          = '0;
        dec_o.asz      = op_i[3:2];
        dec_o.pmode    = op_i[3:2];
        dec_o.dsz      = op_i[1:0];
        if (!op_i[4]) begin
            unique case (grp)
                OP_LD_DIR: begin
                    dec_o.valid   = 1'b1;
                    dec_o.is_load = 1'b1;
                end
                OP_ST_DIR: begin
                    dec_o.valid   = 1'b1;
                end
                OP_LD_IND: begin
                    dec_o.valid    = (op_i[3:2] != 2'b11);
                    dec_o.is_load  = 1'b1;
                    dec_o.indirect = 1'b1;
                end
                OP_ST_IND: begin
                    dec_o.valid    = (op_i[3:2] != 2'b11);
                    dec_o.indirect = 1'b1;
                end
                OP_RST_WR: begin
                    dec_o.valid  = 1'b1;
                    dec_o.rst_wr = 1'b1;
                end
                default: dec_o.valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_ptr_reg.sv
module dbg_ptr_reg #(
    parameter int PTR_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_idx,
    input  logic [7:0]             wr_byte,
    input  logic                   inc_en,
    output logic [8*PTR_BYTES-1:0] ptr_o
);
    localparam int PTR_W = 8 * PTR_BYTES;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;

    assign ptr_inc = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
    assign ptr_o   = ptr_q;

    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[8*b +: 8] <= 8'h00;
            end else if (wr_en && (int'(wr_idx) == b)) begin
                ptr_q[8*b +: 8] <= wr_byte;
            end else if (inc_en) begin
                ptr_q[8*b +: 8] <= ptr_inc[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/dbg_brk_track.sv
module dbg_brk_track (
    input  logic clk,
    input  logic rst,
    input  logic brk_i,
    input  logic byte_acc_i,
    output logic resync_o
);
    logic seen_q;

    assign resync_o = brk_i && seen_q;

    always_ff @(posedge clk) begin
        if (rst || resync_o) begin
            seen_q <= 1'b0;
        end else if (brk_i) begin
            seen_q <= 1'b1;
        end else if (byte_acc_i) begin
            seen_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_pkg::*;
#(
    parameter int ADDR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    output logic                    rx_ready,
    input  logic                    brk_pulse,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [8*ADDR_BYTES-1:0] bus_addr,
    output logic [7:0]              bus_wdata,
    input  logic [7:0]              bus_rdata,
    output logic                    bus_rd,
    output logic                    bus_wr,
    input  logic                    bus_ready,
    input  logic                    ext_rst_req,
    output logic                    dev_reset
);
    localparam int ADDR_W = 8 * ADDR_BYTES;

    eng_state_t       state_q, state_d;
    dec_t             dec_in, cur_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ptr;
    logic [1:0]       idx_q;
    logic [7:0]       txbuf_q;
    logic [7:0]       wdata_q;
    logic [7:0]       rstreg_q;
    logic             rx_acc, resync, last_byte;
    logic             ptr_wr, ptr_inc;
    logic [1:0]       ptr_sel;

    dbg_opcode_dec u_dec (
        .op_i  (rx_data),
        .dec_o (dec_in)
    );

    dbg_brk_track u_brk (
        .clk        (clk),
        .rst        (rst),
        .brk_i      (brk_pulse),
        .byte_acc_i (rx_acc),
        .resync_o   (resync)
    );

    dbg_ptr_reg #(.PTR_BYTES(ADDR_BYTES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ptr_wr),
        .wr_idx  (idx_q),
        .wr_byte (rx_data),
        .inc_en  (ptr_inc),
        .ptr_o   (ptr)
    );

    assign rx_acc    = rx_valid && rx_ready;
    assign last_byte = (idx_q == cur_q.dsz);
    assign ptr_sel   = idx_q + 2'd1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (resync) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_acc && dec_in.valid) begin
                        if (dec_in.rst_wr) begin
                            state_d = ST_RSTDATA;
                        end else if (!dec_in.indirect) begin
                            state_d = ST_ADDR;
                        end else if (!dec_in.is_load) begin
                            state_d = ST_WDATA;
                        end else if (dec_in.pmode == PM_PTR) begin
                            state_d = ST_TXBYTE;
                        end else begin
                            state_d = ST_BUSRD;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rx_acc && (idx_q == cur_q.asz)) begin
                        state_d = cur_q.is_load ? ST_BUSRD : ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (rx_acc) begin
                        if (cur_q.indirect && (cur_q.pmode == PM_PTR)) begin
                            state_d = last_byte ? ST_IDLE : ST_WDATA;
                        end else begin
                            state_d = ST_BUSWR;
                        end
                    end
                end
                ST_BUSWR: begin
                    if (bus_ready) begin
                        state_d = last_byte ? ST_IDLE : ST_WDATA;
                    end
                end
                ST_BUSRD: begin
                    if (bus_ready) begin
                        state_d = ST_TXBYTE;
                    end
                end
                ST_TXBYTE: begin
                    if (tx_ready) begin
                        if (last_byte) begin
                            state_d = ST_IDLE;
                        end else if (cur_q.indirect && (cur_q.pmode == PM_PTR)) begin
                            state_d = ST_TXBYTE;
                        end else begin
                            state_d = ST_BUSRD;
                        end
                    end
                end
                ST_RSTDATA: begin
                    if (rx_acc) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Pointer control strobes
    always_comb begin
        ptr_wr  = 1'b0;
        ptr_inc = 1'b0;
        if (!resync) begin
            if ((state_q == ST_WDATA) && rx_acc && cur_q.indirect
                && (cur_q.pmode == PM_PTR)) begin
                ptr_wr = 1'b1;
            end
            if (((state_q == ST_BUSWR) || (state_q == ST_BUSRD)) && bus_ready
                && cur_q.indirect && (cur_q.pmode == PM_INC)) begin
                ptr_inc = 1'b1;
            end
        end
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            addr_q   <= '0;
            idx_q    <= 2'd0;
            txbuf_q  <= 8'h00;
            wdata_q  <= 8'h00;
            rstreg_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (resync) begin
                idx_q <= 2'd0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (rx_acc && dec_in.valid) begin
                            cur_q   <= dec_in;
                            idx_q   <= 2'd0;
                            addr_q  <= '0;
                            txbuf_q <= ptr[7:0];
                        end
                    end
                    ST_ADDR: begin
                        if (rx_acc) begin
                            addr_q[8*idx_q +: 8] <= rx_data;
                            idx_q <= (idx_q == cur_q.asz) ? 2'd0 : idx_q + 2'd1;
                        end
                    end
                    ST_WDATA: begin
                        if (rx_acc) begin
                            wdata_q <= rx_data;
                            if (cur_q.indirect && (cur_q.pmode == PM_PTR)) begin
                                idx_q <= last_byte ? 2'd0 : idx_q + 2'd1;
                            end
                        end
                    end
                    ST_BUSWR: begin
                        if (bus_ready) begin
                            idx_q <= last_byte ? 2'd0 : idx_q + 2'd1;
                            if (!cur_q.indirect) begin
                                addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
                            end
                        end
                    end
                    ST_BUSRD: begin
                        if (bus_ready) begin
                            txbuf_q <= bus_rdata;
                            if (!cur_q.indirect) begin
                                addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
                            end
                        end
                    end
                    ST_TXBYTE: begin
                        if (tx_ready) begin
                            idx_q <= last_byte ? 2'd0 : idx_q + 2'd1;
                            if (cur_q.indirect && (cur_q.pmode == PM_PTR)) begin
                                txbuf_q <= ptr[8*ptr_sel +: 8];
                            end
                        end
                    end
                    ST_RSTDATA: begin
                        if (rx_acc) begin
                            rstreg_q <= rx_data;
                        end
                    end
                    default: idx_q <= 2'd0;
                endcase
            end
        end
    end

    // Output logic
    always_comb begin
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        tx_data   = txbuf_q;
        bus_wdata = wdata_q;
        bus_addr  = cur_q.indirect ? ptr : addr_q;
        dev_reset = (rstreg_q != 8'h00) || ext_rst_req;
        unique case (state_q)
            ST_IDLE, ST_ADDR, ST_WDATA, ST_RSTDATA: rx_ready = 1'b1;
            ST_BUSWR:  bus_wr   = 1'b1;
            ST_BUSRD:  bus_rd   = 1'b1;
            ST_TXBYTE: tx_valid = 1'b1;
            default:   rx_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_ready,
    input logic        brk_pulse,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [31:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_ready,
    input logic        ext_rst_req,
    input logic        dev_reset
);
    assert_bus_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ready && !brk_pulse) |=> (bus_rd && $stable(bus_addr)));

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ready && !brk_pulse)
            |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !brk_pulse) |=> (tx_valid && $stable(tx_data)));

    assert_no_rx_during_bus_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> !rx_ready);

    assert_ext_reset_R10: assert property (@(posedge clk) disable iff (rst)
        ext_rst_req |-> dev_reset);

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_rd && !bus_wr && !tx_valid && rx_ready
                        && (!dev_reset || ext_rst_req)));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_ready    (rx_ready),
    .brk_pulse   (brk_pulse),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_ready   (bus_ready),
    .ext_rst_req (ext_rst_req),
    .dev_reset   (dev_reset)
);

// File: tb/dbg_cmd_engine_tb.sv
`timescale 1ns/1ps
module dbg_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        brk_pulse = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_rd, bus_wr;
    logic        bus_ready = 1'b0;
    logic        ext_rst_req = 1'b0;
    logic        dev_reset;

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    int n_rd = 0;
    logic [31:0] first_wr_addr, last_wr_addr;
    logic [7:0]  env_mem [256];
    logic [7:0]  exp_mem [256];
    logic [31:0] exp_ptr = 32'h0;

    always #10 clk = ~clk;

    dbg_cmd_engine u_dut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .brk_pulse(brk_pulse), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_ready(bus_ready), .ext_rst_req(ext_rst_req),
        .dev_reset(dev_reset)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus responder with random wait states
    initial begin
        forever begin
            @(negedge clk);
            if ((bus_rd || bus_wr) && ($urandom % 3 != 0)) begin
                bus_ready = 1'b1;
                if (bus_wr) begin
                    env_mem[bus_addr[7:0]] = bus_wdata;
                    if (n_wr == 0) first_wr_addr = bus_addr;
                    last_wr_addr = bus_addr;
                    n_wr++;
                end else begin
                    bus_rdata = env_mem[bus_addr[7:0]];
                    n_rd++;
                end
            end else begin
                bus_ready = 1'b0;
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        b = 8'h00;
        forever begin
            @(negedge clk);
            if (tx_valid && ($urandom % 2 == 0)) begin
                tx_ready = 1'b1;
                b = tx_data;
                @(negedge clk);
                tx_ready = 1'b0;
                break;
            end
        end
    endtask

    task automatic wait_idle();
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic brk();
        @(negedge clk);
        brk_pulse = 1'b1;
        @(negedge clk);
        brk_pulse = 1'b0;
    endtask

    function automatic logic [31:0] trunc_addr(input logic [31:0] a, input int asz);
        return (asz == 3) ? a : (a & ((32'h1 << (8 * (asz + 1))) - 32'h1));
    endfunction

    task automatic set_ptr(input logic [31:0] v);   // R9: mode 10 store, 4 bytes
        send(8'h6B);
        for (int i = 0; i < 4; i++) send(v[8*i +: 8]);
        exp_ptr = v;
    endtask

    task automatic check_ptr(input string req);     // R8: mode 10 load, 4 bytes
        logic [31:0] v;
        logic [7:0]  b;
        send(8'h2B);
        for (int i = 0; i < 4; i++) begin
            recv(b);
            v[8*i +: 8] = b;
        end
        chk(v == exp_ptr, req, v, exp_ptr);
    endtask

    task automatic dir_store(input logic [31:0] a, input int asz, input int dsz);
        logic [31:0] ta;
        logic [7:0]  d;
        ta = trunc_addr(a, asz);
        send(8'h40 | 8'(asz << 2) | 8'(dsz));
        for (int i = 0; i <= asz; i++) send(a[8*i +: 8]);
        for (int i = 0; i <= dsz; i++) begin
            d = 8'($urandom);
            exp_mem[8'(ta + 32'(i))] = d;
            send(d);
        end
        wait_idle();
        chk(last_wr_addr == ta + 32'(dsz), "R2 last write address", last_wr_addr,
            ta + 32'(dsz));
    endtask

    task automatic dir_load(input logic [31:0] a, input int asz, input int dsz);
        logic [31:0] ta;
        logic [7:0]  b;
        ta = trunc_addr(a, asz);
        send(8'h00 | 8'(asz << 2) | 8'(dsz));
        for (int i = 0; i <= asz; i++) send(a[8*i +: 8]);
        for (int i = 0; i <= dsz; i++) begin
            recv(b);
            chk(b == exp_mem[8'(ta + 32'(i))], "R3 direct load byte", 32'(b),
                32'(exp_mem[8'(ta + 32'(i))]));
        end
        wait_idle();
    endtask

    task automatic ind_store(input int mode, input int dsz);
        logic [7:0] d;
        send(8'h60 | 8'(mode << 2) | 8'(dsz));
        for (int i = 0; i <= dsz; i++) begin
            d = 8'($urandom);
            exp_mem[exp_ptr[7:0]] = d;
            if (mode == 1) exp_ptr = exp_ptr + 32'h1;
            send(d);
        end
        wait_idle();
    endtask

    task automatic ind_load(input int mode, input int dsz);
        logic [7:0] b;
        send(8'h20 | 8'(mode << 2) | 8'(dsz));
        for (int i = 0; i <= dsz; i++) begin
            recv(b);
            chk(b == exp_mem[exp_ptr[7:0]], (mode == 1) ? "R7 incr load" : "R6 fixed load",
                32'(b), 32'(exp_mem[exp_ptr[7:0]]));
            if (mode == 1) exp_ptr = exp_ptr + 32'h1;
        end
        wait_idle();
    endtask

    initial begin
        int wr0;
        logic [7:0] b;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            env_mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk(rx_ready && !tx_valid && !bus_rd && !bus_wr, "R12 idle after reset",
            {rx_ready, tx_valid, bus_rd, bus_wr}, 32'h8);
        chk(!dev_reset, "R12 reset output low", 32'(dev_reset), 32'h0);
        check_ptr("R12 pointer zero after reset");

        // R8/R9: pointer write and read, partial write keeps upper bytes
        set_ptr(32'hA1B2C3D4);
        check_ptr("R9 pointer written");
        send(8'h68); send(8'h55);
        exp_ptr[7:0] = 8'h55;
        check_ptr("R9 single pointer byte");
        chk(n_wr == 0 && n_rd == 0, "R8 R9 no bus cycle", 32'(n_wr + n_rd), 32'h0);

        // R2: direct store, 2 address bytes, zero extension, increments
        dir_store(32'hFFFF1234, 1, 2);
        chk(first_wr_addr == 32'h00001234, "R2 zero-extended address", first_wr_addr,
            32'h00001234);
        dir_load(32'h00001234, 1, 2);

        // R1: ignored opcodes
        wr0 = n_wr + n_rd;
        send(8'h80); send(8'hA3); send(8'hE0); send(8'h50); send(8'h2C); send(8'h6C);
        @(negedge clk);
        chk(rx_ready && (n_wr + n_rd == wr0), "R1 unknown opcodes ignored",
            32'(n_wr + n_rd), 32'(wr0));
        check_ptr("R1 pointer untouched by ignored opcodes");

        // R7: wrap of post-increment
        set_ptr(32'hFFFFFFFF);
        ind_store(1, 1);
        chk(first_wr_addr != 32'hx && last_wr_addr == 32'h00000000, "R7 wrapped address",
            last_wr_addr, 32'h0);
        check_ptr("R7 pointer after wrap");

        // R6: fixed pointer mode
        set_ptr(32'h00000040);
        ind_store(0, 3);
        chk(last_wr_addr == 32'h40, "R6 fixed address", last_wr_addr, 32'h40);
        check_ptr("R6 pointer unchanged");
        ind_load(0, 2);

        // R10: reset register
        send(8'hC0); send(8'h01);
        @(negedge clk);
        chk(dev_reset, "R10 reset asserted", 32'(dev_reset), 32'h1);
        ext_rst_req = 1'b1;
        send(8'hC0); send(8'h00);
        @(negedge clk);
        chk(dev_reset, "R10 held by other request", 32'(dev_reset), 32'h1);
        ext_rst_req = 1'b0;
        @(negedge clk);
        chk(!dev_reset, "R10 released", 32'(dev_reset), 32'h0);

        // R11: double BREAK abandons a partial instruction
        wr0 = n_wr;
        send(8'h4C); send(8'h10); send(8'h20);
        chk(n_wr == wr0, "R2 no bus cycle before address complete", 32'(n_wr), 32'(wr0));
        brk(); brk();
        check_ptr("R11 resynchronised");
        chk(n_wr == wr0, "R11 no write after resync", 32'(n_wr), 32'(wr0));

        // R11: a single BREAK leaves the instruction intact
        send(8'h40); brk(); send(8'h77);
        b = 8'h5A;
        exp_mem[8'h77] = b;
        send(b);
        wait_idle();
        dir_load(32'h77, 0, 0);

        // R12: mid-run reset clears pointer and reset register
        set_ptr(32'h12345678);
        send(8'hC0); send(8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_ptr = 32'h0;
        @(negedge clk);
        chk(!dev_reset, "R12 reset register cleared", 32'(dev_reset), 32'h0);
        check_ptr("R12 pointer cleared");

        // Random mix of accesses
        for (int k = 0; k < 200; k++) begin
            int kind, asz, dsz;
            logic [31:0] a;
            kind = int'($urandom % 6);
            asz  = int'($urandom % 4);
            dsz  = int'($urandom % 4);
            a    = $urandom;
            unique case (kind)
                0: dir_store(a, asz, dsz);
                1: dir_load(a, asz, dsz);
                2: ind_store(int'($urandom % 2), dsz);
                3: ind_load(int'($urandom % 2), dsz);
                4: set_ptr($urandom);
                default: check_ptr("R7 pointer tracking");
            endcase
        end
        finish_run();
    end
endmodule